// File: doc/BRIEF.md
# Write-Completion Status Read Responder

This block sits on the read path of a nonvolatile memory model. While an internal program or erase cycle runs, software cannot read the array. It can only poll for completion. The block keeps a copy of the most recently loaded byte and its address. While status mode is active, every read returns a status byte built from that copy instead of array data.

Two completion indicators are merged into the status byte:

- **Polling bit (bit 7).** It returns the inverted value of the captured byte's top bit, but only when the read targets the captured address.
- **Toggle bit (bit 6).** It reads 1 on the first read after status mode starts and flips on every later read.

During an erase cycle only the toggle bit carries meaning, and bit 7 is passed through uninverted. Status mode starts on the rising edge of the byte-load strobe. It ends on the clock edge that sees the busy input fall. From then on reads return array data, so two reads in a row agree.

Top module: `wstat_resp`

## Requirements
- R1: After reset, data_o is 0 and status mode is inactive, so a read returns array_data_i.
- R2: data_o is updated only at the clock edge where rd_stb_i is high, and holds its value on every other edge.
- R3: A rising edge of ld_stb_i, seen while busy_i is low in that cycle and in the previous cycle, captures ld_addr_i and ld_data_i and starts status mode.
- R4: In status mode with erase_i low, a read whose address equals the captured address returns bit 7 as the inverse of captured bit 7.
- R5: In status mode, bits 5..0 come from the captured byte. Bit 7 is the true captured bit 7 when the read address differs from the captured address.
- R6: In status mode, bit 6 is 1 on the first read after status mode starts and inverts on each further read. Clock cycles without a read do not advance it.
- R7: A load edge while status mode is already active and busy_i is low replaces the captured byte and address without restarting the bit-6 sequence.
- R8: In status mode with erase_i high, bit 7 returns captured bit 7 uninverted and bit 6 keeps toggling.
- R9: Status mode ends at the clock edge that sees busy_i low after it was high. Later reads return array_data_i, so consecutive reads of one address match.
- R10: A load edge that arrives while busy_i is high, or in the cycle busy_i falls, neither captures data nor starts status mode.
- R11: A load strobe held high for several cycles captures only once, using the data present at its rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| busy_i | input | 1 | Internal program/erase cycle running |
| erase_i | input | 1 | 1 = running cycle is an erase, 0 = program |
| ld_stb_i | input | 1 | Byte-load strobe, active high; rising edge latches |
| ld_addr_i | input | ADDR_W (18) | Address of byte being loaded |
| ld_data_i | input | DATA_W (8) | Byte being loaded |
| rd_stb_i | input | 1 | Read strobe, one cycle per read |
| rd_addr_i | input | ADDR_W (18) | Read address |
| array_data_i | input | DATA_W (8) | Array contents at rd_addr_i, same cycle |
| data_o | output | DATA_W (8) | Registered read data |

## Verification
Read results appear one clock edge after the cycle in which rd_stb_i is high. The bench raises the strobe on a falling edge, drops it on the next falling edge, and compares data_o there, one rising edge later.

A load edge changes state one edge after the strobe rises, and busy falling takes effect one edge after it is driven low. Each task therefore idles at least one full cycle after such a change before it issues the read that depends on it.

The toggle check puts idle cycles between reads, which separates per-read advance from per-clock advance.

// File: rtl/wstat_pkg.sv
package wstat_pkg;
  typedef enum logic [1:0] {
    RM_ARRAY = 2'd0,
    RM_WRITE = 2'd1,
    RM_ERASE = 2'd2
  } rd_mode_e;
endpackage

// File: rtl/wstat_capture.sv
module wstat_capture #(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              busy_i,
  input  logic              ld_stb_i,
  input  logic [ADDR_W-1:0] ld_addr_i,
  input  logic [DATA_W-1:0] ld_data_i,
  output logic              armed_o,
  output logic              arm_start_o,
  output logic [ADDR_W-1:0] last_addr_o,
  output logic [DATA_W-1:0] last_data_o
);
  logic stb_q, busy_q, armed_q;
  logic stb_rise, busy_fall, accept;

  assign stb_rise  = ld_stb_i & ~stb_q;
  assign busy_fall = busy_q & ~busy_i;
  // loads are dropped while busy and on the edge busy drops
  assign accept    = stb_rise & ~busy_i & ~busy_q;

  assign arm_start_o = accept & ~armed_q;
  assign armed_o     = armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stb_q  <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      stb_q  <= ld_stb_i;
      busy_q <= busy_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
    end else if (busy_fall) begin
      armed_q <= 1'b0;
    end else if (accept) begin
      armed_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_addr_o <= '0;
      last_data_o <= '0;
    end else if (accept) begin
      last_addr_o <= ld_addr_i;
      last_data_o <= ld_data_i;
    end
  end
endmodule

// File: rtl/wstat_toggle.sv
module wstat_toggle (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_start_i,
  input  logic rd_adv_i,
  output logic tog_o
);
  logic tog_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tog_q <= 1'b1;
    end else if (arm_start_i) begin
      tog_q <= 1'b1;
    end else if (rd_adv_i) begin
      tog_q <= ~tog_q;
    end
  end

  assign tog_o = tog_q;
endmodule

// File: rtl/wstat_read_mux.sv
module wstat_read_mux #(
  parameter int ADDR_W   = 18,
  parameter int DATA_W   = 8,
  parameter int POLL_BIT = DATA_W - 1,
  parameter int TOG_BIT  = DATA_W - 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_stb_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [DATA_W-1:0] array_data_i,
  input  logic              armed_i,
  input  logic              erase_i,
  input  logic              tog_i,
  input  logic [ADDR_W-1:0] last_addr_i,
  input  logic [DATA_W-1:0] last_data_i,
  output logic [DATA_W-1:0] data_o
);
  import wstat_pkg::*;

  rd_mode_e          mode;
  logic              addr_hit;
  logic [DATA_W-1:0] stat_byte, rd_next, data_q;

  assign addr_hit = (rd_addr_i == last_addr_i);

  always_comb begin
    if (!armed_i)     mode = RM_ARRAY;
    else if (erase_i) mode = RM_ERASE;
    else              mode = RM_WRITE;
  end

  always_comb begin
    for (int b = 0; b < DATA_W; b++) begin
      if (b == TOG_BIT)
        stat_byte[b] = tog_i;
      else if (b == POLL_BIT)
        stat_byte[b] = last_data_i[b] ^ (mode == RM_WRITE && addr_hit);
      else
        stat_byte[b] = last_data_i[b];
    end
  end

  always_comb begin
    unique case (mode)
      RM_WRITE, RM_ERASE: rd_next = stat_byte;
      default:            rd_next = array_data_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       data_q <= '0;
    else if (rd_stb_i) data_q <= rd_next;
  end

  assign data_o = data_q;
endmodule

// File: rtl/wstat_resp.sv
module wstat_resp #(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              busy_i,
  input  logic              erase_i,
  input  logic              ld_stb_i,
  input  logic [ADDR_W-1:0] ld_addr_i,
  input  logic [DATA_W-1:0] ld_data_i,
  input  logic              rd_stb_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [DATA_W-1:0] array_data_i,
  output logic [DATA_W-1:0] data_o
);
  localparam int POLL_BIT = DATA_W - 1;
  localparam int TOG_BIT  = DATA_W - 2;

  logic              armed, arm_start, tog;
  logic [ADDR_W-1:0] last_addr;
  logic [DATA_W-1:0] last_data;

  wstat_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) cap_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .busy_i      (busy_i),
    .ld_stb_i    (ld_stb_i),
    .ld_addr_i   (ld_addr_i),
    .ld_data_i   (ld_data_i),
    .armed_o     (armed),
    .arm_start_o (arm_start),
    .last_addr_o (last_addr),
    .last_data_o (last_data)
  );

  wstat_toggle tog_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .arm_start_i (arm_start),
    .rd_adv_i    (rd_stb_i & armed),
    .tog_o       (tog)
  );

  wstat_read_mux #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .POLL_BIT(POLL_BIT), .TOG_BIT(TOG_BIT)
  ) mux_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rd_stb_i     (rd_stb_i),
    .rd_addr_i    (rd_addr_i),
    .array_data_i (array_data_i),
    .armed_i      (armed),
    .erase_i      (erase_i),
    .tog_i        (tog),
    .last_addr_i  (last_addr),
    .last_data_i  (last_data),
    .data_o       (data_o)
  );
endmodule

// File: rtl/wstat_resp_chk.sv
module wstat_resp_chk #(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_i,
  input logic              erase_i,
  input logic              rd_stb_i,
  input logic [ADDR_W-1:0] rd_addr_i,
  input logic [DATA_W-1:0] array_data_i,
  input logic [DATA_W-1:0] data_o,
  input logic              armed,
  input logic [ADDR_W-1:0] last_addr,
  input logic [DATA_W-1:0] last_data
);
  localparam int PB = DATA_W - 1;
  localparam int TB = DATA_W - 2;

  logic armed_d, rd_d, first_d, pend, prev6, first_now;

  assign first_now = (armed & ~armed_d) | pend;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_d <= 1'b0;
      rd_d    <= 1'b0;
      first_d <= 1'b0;
      pend    <= 1'b0;
      prev6   <= 1'b0;
    end else begin
      armed_d <= armed;
      rd_d    <= rd_stb_i & armed;
      if (rd_stb_i & armed) first_d <= first_now;
      pend    <= first_now & ~(rd_stb_i & armed);
      if (rd_d) prev6 <= data_o[TB];
    end
  end

  AST_HOLD_NO_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_stb_i |=> $stable(data_o)); // R2
  AST_ARRAY_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_stb_i && !armed) |=> data_o == $past(array_data_i)); // R9
  AST_POLL_INVERT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_stb_i && armed && !erase_i && rd_addr_i == last_addr)
      |=> data_o[PB] == !$past(last_data[PB])); // R4
  AST_ERASE_TRUE7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_stb_i && armed && erase_i) |=> data_o[PB] == $past(last_data[PB])); // R8
  AST_TOG_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_d && first_d) |-> data_o[TB]); // R6
  AST_TOG_ALT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_d && !first_d) |-> data_o[TB] != prev6); // R6
  AST_BUSY_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> ($stable(last_data) && $stable(last_addr))); // R10
endmodule

bind wstat_resp wstat_resp_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (.*);

// File: tb/wstat_resp_tb_top.sv
`timescale 1ns/1ps
module wstat_resp_tb_top;
  localparam int AW = 18;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          busy = 1'b0, erase = 1'b0, ld_stb = 1'b0, rd_stb = 1'b0;
  logic [AW-1:0] ld_addr = '0, rd_addr = '0;
  logic [DW-1:0] ld_data = '0, arr_data, dout;
  int            n_chk = 0, n_fail = 0;
  bit            done = 1'b0;

  always #2 clk = ~clk;

  function automatic logic [DW-1:0] arr_of(input logic [AW-1:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  assign arr_data = arr_of(rd_addr);

  function automatic logic [DW-1:0] stat(input logic [DW-1:0] d, input logic inv, input logic b6);
    return {d[7] ^ inv, b6, d[5:0]};
  endfunction

  wstat_resp #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .busy_i(busy), .erase_i(erase),
    .ld_stb_i(ld_stb), .ld_addr_i(ld_addr), .ld_data_i(ld_data),
    .rd_stb_i(rd_stb), .rd_addr_i(rd_addr), .array_data_i(arr_data),
    .data_o(dout)
  );

  task automatic check(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk); ld_stb = 1'b1; ld_addr = a; ld_data = d;
    @(negedge clk); ld_stb = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] v);
    @(negedge clk); rd_stb = 1'b1; rd_addr = a;
    @(negedge clk); rd_stb = 1'b0;
    v = dout;
  endtask

  task automatic finish_cycle;
    @(negedge clk); busy = 1'b0;
    idle(2);
  endtask

  task automatic t_reset;
    logic [DW-1:0] v;
    check("R1 reset value", dout, 8'h00);
    rd(18'h00123, v);
    check("R1 idle read", v, arr_of(18'h00123));
  endtask

  task automatic t_write_poll;
    logic [DW-1:0] v, v2;
    load(18'h01040, 8'hC3);
    busy = 1'b1;
    rd(18'h01040, v);
    check("R4 R6 first poll", v, stat(8'hC3, 1'b1, 1'b1));
    idle(3);
    v2 = dout;
    check("R2 hold w/o read", v2, v);
    rd(18'h01040, v);
    check("R6 second poll", v, stat(8'hC3, 1'b1, 1'b0));
    rd(18'h00007, v);
    check("R5 other addr", v, stat(8'hC3, 1'b0, 1'b1));
    finish_cycle();
    rd(18'h01040, v);
    rd(18'h01040, v2);
    check("R9 array after done", v, arr_of(18'h01040));
    check("R9 stable reads", v2, v);
  endtask

  task automatic t_held_strobe;
    logic [DW-1:0] v;
    @(negedge clk); ld_stb = 1'b1; ld_addr = 18'h02200; ld_data = 8'h81;
    @(negedge clk); ld_data = 8'h3C;
    @(negedge clk); ld_data = 8'h18;
    @(negedge clk); ld_stb = 1'b0;
    busy = 1'b1;
    rd(18'h02200, v);
    check("R11 R3 held strobe", v, stat(8'h81, 1'b1, 1'b1));
    finish_cycle();
  endtask

  task automatic t_page_reload;
    logic [DW-1:0] v;
    load(18'h03300, 8'h2A);
    rd(18'h03300, v);
    check("R3 R4 armed before busy", v, stat(8'h2A, 1'b1, 1'b1));
    load(18'h03301, 8'hD5);
    rd(18'h03301, v);
    check("R7 reload no restart", v, stat(8'hD5, 1'b1, 1'b0));
    busy = 1'b1;
    rd(18'h03300, v);
    check("R7 old addr not hit", v, stat(8'hD5, 1'b0, 1'b1));
    finish_cycle();
  endtask

  task automatic t_busy_ignore;
    logic [DW-1:0] v;
    load(18'h04410, 8'h15);
    busy = 1'b1;
    load(18'h04411, 8'hEE);
    rd(18'h04410, v);
    check("R10 load in busy ignored", v, stat(8'h15, 1'b1, 1'b1));
    rd(18'h04411, v);
    check("R10 addr kept", v, stat(8'h15, 1'b0, 1'b0));
    @(negedge clk); busy = 1'b0; ld_stb = 1'b1; ld_addr = 18'h04520; ld_data = 8'h77;
    @(negedge clk); ld_stb = 1'b0;
    idle(1);
    rd(18'h04520, v);
    check("R10 load at busy fall ignored", v, arr_of(18'h04520));
  endtask

  task automatic t_erase;
    logic [DW-1:0] v;
    erase = 1'b1;
    load(18'h05050, 8'hA6);
    busy = 1'b1;
    rd(18'h05050, v);
    check("R8 erase first", v, stat(8'hA6, 1'b0, 1'b1));
    rd(18'h05050, v);
    check("R8 erase toggles", v, stat(8'hA6, 1'b0, 1'b0));
    finish_cycle();
    erase = 1'b0;
    rd(18'h05050, v);
    check("R9 after erase", v, arr_of(18'h05050));
  endtask

  task automatic report;
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_write_poll();
    t_held_strobe();
    t_page_reload();
    t_busy_ignore();
    t_erase();
    idle(2);
    report();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
  end
endmodule